// File: doc/BRIEF.md
# Video Comb/Bypass Mode Controller

This controller chooses whether a video luminance/chrominance separation chain runs in comb mode or is bypassed. It watches three slow control inputs: a raw bypass request pin, a select pin that both sets the polarity of that request and chooses how comb mode is entered, and a vertical pulse from a sync detector. From them it drives a stop line that steers all three output selectors (luminance, chrominance and composite) to pass the external inputs through, a run enable for the PLL and clock processing, and a status flag that reads high only while combing.

The select and request pins are combined by exclusive OR: equal levels ask for comb, unequal levels ask for bypass. Leaving comb mode never waits for anything. Entering it happens straight away when the select pin is low. When the select pin is high, the controller first waits in a pending state with the clocks already running, and only a fresh rising edge of the vertical pulse lets it into comb mode. All three inputs pass through a two-stage synchronizer on the system clock, so every decision lands on the third rising clock edge after an input changes.

The controller has three named states: BYPASS (stop high, clocks stopped), PEND (stop high, clocks running, waiting for a vertical edge) and COMB (stop low, clocks running). Transitions: BYPASS→COMB when comb is requested with select low; BYPASS→PEND when comb is requested with select high; PEND→COMB on a vertical rising edge, or at once if select falls while comb is still requested; PEND→BYPASS when the request returns to bypass (cancel); COMB→BYPASS when bypass is requested.

Top module: `comb_mode_ctrl`

## Requirements
- R1: While reset is asserted the outputs are stop_o=1, clk_run_o=0, comb_active_o=0 (BYPASS); the synchronizer holds a bypass decode so that the first mode change after reset follows the real pins.
- R2: The decoded request is bypass when sel_i XOR byp_req_i is 1 and comb when it is 0 (LOW/LOW and HIGH/HIGH ask for comb).
- R3: With sel_i=0 and a comb decode, the outputs become stop_o=0, clk_run_o=1, comb_active_o=1 at the third rising clock edge after the pins change, and not earlier.
- R4: A bypass decode forces stop_o=1, clk_run_o=0, comb_active_o=0 at the third rising edge after the pin change, from COMB or PEND, whatever the vertical pulse does.
- R5: With sel_i=1 and a comb decode, the controller waits in PEND (stop_o=1, clk_run_o=1, comb_active_o=0) and enters COMB at the third rising edge after a rising edge of vpulse_i.
- R6: clk_run_o is 0 exactly in BYPASS; it is 1 whenever comb_active_o is 1.
- R7: Only a rising edge of vpulse_i releases a pending entry: a pulse level that is already high when PEND starts, or that stays high, releases nothing.
- R8: If the decode returns to bypass while in PEND, the pending entry is dropped; a vertical pulse arriving in BYPASS has no effect and a later comb request waits for a new edge.
- R9: stop_o and comb_active_o are complements at all times.
- R10: In PEND, if select falls while the decode stays comb (both pins move from HIGH/HIGH to LOW/LOW), COMB is entered at the third edge without a vertical pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byp_req_i | input | 1 | Raw bypass request pin, polarity set by sel_i |
| sel_i | input | 1 | Polarity and entry-mode select (0: immediate entry, 1: vertical-gated entry) |
| vpulse_i | input | 1 | Vertical pulse from the sync detector |
| stop_o | output | 1 | 1 forces all output selectors to pass the external inputs |
| clk_run_o | output | 1 | Run enable for PLL and clock processing |
| comb_active_o | output | 1 | Status: 1 only while combing |

## Verification
A wrong state shows up at the ports as a wrong triple on stop_o, clk_run_o and comb_active_o, because each of the three states has its own output pattern. A bad transition therefore shows at the third clock edge after the stimulus that should or should not have caused it, and a stuck PEND shows for as long as no fresh vertical edge arrives. The bench sweeps all sixteen pairs of previous and next pin settings and checks the outputs both one edge before and at the decision edge. It then drives the held-pulse, cancel and select-drop sequences, where a lost or duplicated edge or a wrong cancel would put out the PEND or COMB pattern at the wrong time.

// File: rtl/comb_mode_pkg.sv
package comb_mode_pkg;

    typedef enum logic [1:0] {
        MODE_BYPASS = 2'd0,
        MODE_PEND   = 2'd1,
        MODE_COMB   = 2'd2
    } mode_state_t;

endpackage

// File: rtl/cm_bit_sync.sv
module cm_bit_sync #(
    parameter int          WIDTH   = 3,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe[0] <= RST_VAL;
        end else begin
            pipe[0] <= d;
        end
    end

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pipe[g] <= RST_VAL;
                end else begin
                    pipe[g] <= pipe[g-1];
                end
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/cm_edge_detect.sv
module cm_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);
    logic level_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_d <= 1'b0;
        end else begin
            level_d <= level;
        end
    end

    assign rise = level & ~level_d;
endmodule

// File: rtl/cm_mode_fsm.sv
module cm_mode_fsm
    import comb_mode_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic byp_want,
    input  logic sel,
    input  logic v_rise,
    output logic stop_o,
    output logic clk_run_o,
    output logic comb_active_o
);
    mode_state_t state_q, state_d;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_BYPASS: begin
                if (!byp_want) begin
                    state_d = sel ? MODE_PEND : MODE_COMB;
                end
            end
            MODE_PEND: begin
                if (byp_want) begin
                    state_d = MODE_BYPASS;
                end else if (!sel || v_rise) begin
                    state_d = MODE_COMB;
                end
            end
            MODE_COMB: begin
                if (byp_want) begin
                    state_d = MODE_BYPASS;
                end
            end
            default: state_d = MODE_BYPASS;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MODE_BYPASS;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        stop_o        = 1'b1;
        clk_run_o     = 1'b0;
        comb_active_o = 1'b0;
        unique case (state_q)
            MODE_BYPASS: begin
                stop_o        = 1'b1;
                clk_run_o     = 1'b0;
                comb_active_o = 1'b0;
            end
            MODE_PEND: begin
                stop_o        = 1'b1;
                clk_run_o     = 1'b1;
                comb_active_o = 1'b0;
            end
            MODE_COMB: begin
                stop_o        = 1'b0;
                clk_run_o     = 1'b1;
                comb_active_o = 1'b1;
            end
            default: begin
                stop_o        = 1'b1;
                clk_run_o     = 1'b0;
                comb_active_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/comb_mode_ctrl.sv
module comb_mode_ctrl #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic byp_req_i,
    input  logic sel_i,
    input  logic vpulse_i,
    output logic stop_o,
    output logic clk_run_o,
    output logic comb_active_o
);
    localparam int NPINS = 3;
    // bit 0: request, bit 1: select, bit 2: vertical pulse
    localparam logic [NPINS-1:0] PIN_RST = 3'b001;

    logic [NPINS-1:0] pins_s;
    logic             req_s;
    logic             sel_s;
    logic             vp_s;
    logic             v_rise;
    logic             byp_want_s;

    cm_bit_sync #(
        .WIDTH   (NPINS),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({vpulse_i, sel_i, byp_req_i}),
        .q     (pins_s)
    );

    assign req_s      = pins_s[0];
    assign sel_s      = pins_s[1];
    assign vp_s       = pins_s[2];
    assign byp_want_s = sel_s ^ req_s;

    cm_edge_detect u_vedge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (vp_s),
        .rise  (v_rise)
    );

    cm_mode_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .byp_want      (byp_want_s),
        .sel           (sel_s),
        .v_rise        (v_rise),
        .stop_o        (stop_o),
        .clk_run_o     (clk_run_o),
        .comb_active_o (comb_active_o)
    );
endmodule

// File: rtl/comb_mode_chk.sv
module comb_mode_chk (
    input logic clk,
    input logic rst_n,
    input logic byp_want_s,
    input logic sel_s,
    input logic v_rise,
    input logic stop_o,
    input logic clk_run_o,
    input logic comb_active_o
);
    // R9
    stop_vs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o != comb_active_o);

    // R6
    run_in_comb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        comb_active_o |-> clk_run_o);

    // R6
    stopped_means_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_run_o |-> (stop_o && !comb_active_o));

    // R4
    leave_at_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byp_want_s |=> (stop_o && !clk_run_o));

    // R3
    enter_at_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!byp_want_s && !sel_s) |=> comb_active_o);

    // R5
    hold_for_vertical_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!comb_active_o && sel_s && !v_rise) |=> !comb_active_o);

    // R5
    pend_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_run_o && !comb_active_o && !byp_want_s && v_rise) |=> comb_active_o);
endmodule

bind comb_mode_ctrl comb_mode_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .byp_want_s    (byp_want_s),
    .sel_s         (sel_s),
    .v_rise        (v_rise),
    .stop_o        (stop_o),
    .clk_run_o     (clk_run_o),
    .comb_active_o (comb_active_o)
);

// File: tb/sim_comb_mode_ctrl.sv
module sim_comb_mode_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic byp_req_i = 1'b1;
    logic sel_i = 1'b0;
    logic vpulse_i = 1'b0;
    logic stop_o, clk_run_o, comb_active_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // output patterns {stop, run, active}
    localparam logic [2:0] P_BYP  = 3'b100;
    localparam logic [2:0] P_PEND = 3'b110;
    localparam logic [2:0] P_COMB = 3'b011;

    always #2 clk = ~clk;

    comb_mode_ctrl u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .byp_req_i     (byp_req_i),
        .sel_i         (sel_i),
        .vpulse_i      (vpulse_i),
        .stop_o        (stop_o),
        .clk_run_o     (clk_run_o),
        .comb_active_o (comb_active_o)
    );

    task automatic check(input string rq, input logic [2:0] exp);
        logic [2:0] act;
        act = {stop_o, clk_run_o, comb_active_o};
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: outputs {stop,run,active} = %b expected %b at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_pins(input logic s, input logic r);
        sel_i = s;
        byp_req_i = r;
    endtask

    task automatic vpulse_once();
        vpulse_i = 1'b1;
        wait_n(2);
        vpulse_i = 1'b0;
        wait_n(4);
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: run hung, actual running expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [2:0] prev_pat, exp_pat;
        // R1: reset state
        wait_n(3);
        check("R1 reset", P_BYP);
        set_pins(1'b0, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;
        wait_n(5);
        check("R1 after reset bypass pins", P_BYP);

        // R2 R3 R4 R5: sweep every previous/next pin pair
        for (int p = 0; p < 4; p++) begin
            for (int n = 0; n < 4; n++) begin
                logic ps, pr, ns, nr, pw, nw;
                ps = p[1]; pr = p[0]; ns = n[1]; nr = n[0];
                pw = (ps == pr);
                nw = (ns == nr);
                set_pins(ps, pr);
                wait_n(6);
                if (pw && ps) vpulse_once();
                prev_pat = pw ? P_COMB : P_BYP;
                check("R2 settled previous decode", prev_pat);
                set_pins(ns, nr);
                if (!nw)                 exp_pat = P_BYP;
                else if (pw)             exp_pat = P_COMB;
                else if (!ns)            exp_pat = P_COMB;
                else                     exp_pat = P_PEND;
                wait_n(2);
                check("R3 R4 no change before third edge", prev_pat);
                @(negedge clk);
                check(nw ? "R3 R5 comb decode at third edge" : "R4 bypass at third edge", exp_pat);
            end
        end

        // R5: pending holds until a vertical rising edge, latency 3
        set_pins(1'b0, 1'b1);
        wait_n(6);
        set_pins(1'b1, 1'b1);
        wait_n(20);
        check("R5 pending waits", P_PEND);
        vpulse_i = 1'b1;
        wait_n(2);
        check("R5 before third edge after pulse", P_PEND);
        @(negedge clk);
        check("R5 comb after vertical edge", P_COMB);
        vpulse_i = 1'b0;

        // R4: leaving comb ignores a vertical pulse
        wait_n(4);
        vpulse_i = 1'b1;
        set_pins(1'b1, 1'b0);
        wait_n(3);
        check("R4 leave with pulse high", P_BYP);
        vpulse_i = 1'b0;
        wait_n(4);

        // R7: level already high when pending starts releases nothing
        vpulse_i = 1'b1;
        wait_n(4);
        set_pins(1'b1, 1'b1);
        wait_n(12);
        check("R7 held level no release", P_PEND);
        vpulse_i = 1'b0;
        wait_n(4);
        check("R7 falling edge no release", P_PEND);
        vpulse_i = 1'b1;
        wait_n(3);
        check("R7 fresh edge releases", P_COMB);
        set_pins(1'b1, 1'b0);
        wait_n(4);
        set_pins(1'b1, 1'b1);
        wait_n(10);
        check("R7 still-high pulse releases only once", P_PEND);
        vpulse_i = 1'b0;
        set_pins(1'b1, 1'b0);
        wait_n(6);

        // R8: cancel pending, pulse in bypass ignored
        set_pins(1'b1, 1'b1);
        wait_n(6);
        check("R8 pending before cancel", P_PEND);
        set_pins(1'b1, 1'b0);
        wait_n(3);
        check("R8 cancel to bypass", P_BYP);
        vpulse_once();
        check("R8 pulse in bypass ignored", P_BYP);
        set_pins(1'b1, 1'b1);
        wait_n(10);
        check("R8 new request waits again", P_PEND);

        // R10: select drop with comb decode kept
        set_pins(1'b0, 1'b0);
        wait_n(2);
        check("R10 before third edge", P_PEND);
        @(negedge clk);
        check("R10 immediate entry", P_COMB);

        // R1: reset from comb
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset from comb", P_BYP);
        rst_n = 1'b1;
        wait_n(3);
        check("R1 R3 reset released with comb pins", P_COMB);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule